// File: doc/BRIEF.md
# Multilevel Cell Drift Test Controller

This controller runs a retention test on a memory array whose cells each hold one of six charge levels, carried on the data bus as a 5-digit thermometer code. Level 0 is `00000` and level 5 is `11111`. Each step up in level sets one more bit, filling from bit 0 upwards. After a start pulse the controller first writes the top level into every cell of a programmable rectangle of rows and columns. It then sits idle for a programmable number of clock cycles so that the stored charge can leak. Last, it reads the rectangle back in page mode: it opens each row once and then reads that row's columns in consecutive cycles.

Every cell that is read produces one result record. The record holds the row, the column, the raw code, the decoded level, a drift flag and an invalid-code flag. An external agent collects the records and builds a drift bitmap from them. Stuck cells, stuck bitlines, stuck wordlines and sense offsets show up as patterns in that bitmap. Records leave through a valid/ready handshake, and back-pressure stalls the page-mode reads.

The state machine has six states:
- IDLE waits for start.
- FILL writes the top level into the rectangle.
- WAIT counts down the drift time.
- OPEN activates one row.
- READ reads the columns of the open row.
- DRAIN waits until the last record has been accepted.

Its transitions are:
- IDLE→FILL on start.
- FILL→WAIT, or FILL→OPEN when the drift count is zero, after the last write.
- WAIT→OPEN when the count expires.
- OPEN→READ always.
- READ→OPEN at the end of a row that is not the last.
- READ→DRAIN at the end of the last row.
- DRAIN→IDLE when the last record is accepted.

The memory port is synchronous and single-ported. A write is taken on the clock edge. During a read cycle the memory presents `mem_rdata` for the row and column it is given, and the controller captures it on the edge that ends that cycle. The range inputs must satisfy first ≤ last.

Top module: `mlc_drift_tester`

## Requirements
- R1: In FILL the controller writes `11111` to every cell of the rectangle. It writes one cell per cycle, in row-major order from (row_first, col_first) to (row_last, col_last).
- R2: The number of cycles between the last fill write and the first row activation equals `drift_cycles`, which is latched at start. A value of 0 gives no gap at all.
- R3: Each row is activated once (`mem_act`, with `mem_en` low) before its columns are read. Its columns are then read in ascending order under the same row, with no activation in between. While `rec_ready` stays high, one column is read per cycle, so the whole read phase takes rows×(columns+1) cycles.
- R4: Records come out in the same row-major order as the reads, and each record carries the row and column of its cell.
- R5: `rec_code` is the code that was read, and `rec_level` is the number of 1 bits in it.
- R6: `rec_drift` is high exactly when `rec_code` is not `11111`.
- R7: `rec_invalid` is high exactly when the code is not one of the six thermometer patterns `00000`, `00001`, `00011`, `00111`, `01111` and `11111`.
- R8: While `rec_valid` is high and `rec_ready` is low, the record fields stay stable and no read is issued.
- R9: `done` is a one-cycle pulse in the cycle after the last record is accepted. `busy` is high from the cycle after start until that cycle, and it is low while `done` is high.
- R10: A start pulse while `busy` is high is ignored: the run in progress finishes with its original range.
- R11: After reset, `busy`, `done`, `rec_valid`, `mem_en` and `mem_act` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a test when idle |
| row_first | input | ROW_W | First row of the rectangle |
| row_last | input | ROW_W | Last row of the rectangle |
| col_first | input | COL_W | First column of the rectangle |
| col_last | input | COL_W | Last column of the rectangle |
| drift_cycles | input | CNT_W | Drift wait in clock cycles |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_act | output | 1 | Row activation (page open) |
| mem_row | output | ROW_W | Row address |
| mem_col | output | COL_W | Column address |
| mem_wdata | output | CODE_W | Write data (top level) |
| mem_rdata | input | CODE_W | Read data for the current read cycle |
| rec_valid | output | 1 | Result record present |
| rec_ready | input | 1 | Consumer accepts record |
| rec_row | output | ROW_W | Record row |
| rec_col | output | COL_W | Record column |
| rec_code | output | CODE_W | Observed code |
| rec_level | output | $clog2(CODE_W+1) | Number of set bits |
| rec_drift | output | 1 | Code differs from top level |
| rec_invalid | output | 1 | Code is not a thermometer pattern |
| busy | output | 1 | Test in progress |
| done | output | 1 | End-of-test pulse |

## Verification
The bench builds the controller with ROW_W=2 and COL_W=2, so a full rectangle is a 4×4 array of 16 cells. Two full-array runs whose injected codes are offset from each other by 16 together put all 32 five-bit codes through the decoder. This covers the valid levels, the drift flag and the invalid flag. Further runs use a partial rectangle with a spurious start, a single cell, zero and non-zero drift counts, and both steady and pseudo-random back-pressure. These runs exercise row changes, the zero-wait path and the stall behaviour.

// File: rtl/mlc_drift_pkg.sv
package mlc_drift_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_OPEN,
        ST_READ,
        ST_DRAIN
    } tst_state_t;
endpackage

// File: rtl/mlc_thermo_decode.sv
module mlc_thermo_decode #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0]           code,
    output logic [$clog2(CODE_W+1)-1:0] level,
    output logic                        is_top,
    output logic                        bad
);
    localparam int LVL_W = $clog2(CODE_W + 1);

    // Level is the number of set bits.
    always_comb begin
        level = '0;
        for (int i = 0; i < CODE_W; i++) begin
            level = level + LVL_W'(code[i]);
        end
    end

    assign is_top = &code;
    // A thermometer pattern plus one has no bit in common with itself.
    assign bad    = |(code & (code + CODE_W'(1)));
endmodule

// File: rtl/mlc_drift_timer.sv
module mlc_drift_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire  = run && (cnt == CNT_W'(1));
    assign is_zero = (cnt == '0);
endmodule

// File: rtl/mlc_addr_walk.sv
module mlc_addr_walk #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_first,
    input  logic [ROW_W-1:0] row_last,
    input  logic [COL_W-1:0] col_first,
    input  logic [COL_W-1:0] col_last,
    input  logic             rewind,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             col_end,
    output logic             at_last
);
    logic [ROW_W-1:0] rf_q, rl_q;
    logic [COL_W-1:0] cf_q, cl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
            rl_q <= '0;
            cf_q <= '0;
            cl_q <= '0;
            row  <= '0;
            col  <= '0;
        end else if (load) begin
            rf_q <= row_first;
            rl_q <= row_last;
            cf_q <= col_first;
            cl_q <= col_last;
            row  <= row_first;
            col  <= col_first;
        end else if (rewind) begin
            row <= rf_q;
            col <= cf_q;
        end else if (step) begin
            if (col_end) begin
                col <= cf_q;
                row <= row + ROW_W'(1);
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end

    assign col_end = (col == cl_q);
    assign at_last = col_end && (row == rl_q);
endmodule

// File: rtl/mlc_drift_tester.sv
module mlc_drift_tester
    import mlc_drift_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int CODE_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ROW_W-1:0]            row_first,
    input  logic [ROW_W-1:0]            row_last,
    input  logic [COL_W-1:0]            col_first,
    input  logic [COL_W-1:0]            col_last,
    input  logic [CNT_W-1:0]            drift_cycles,
    output logic                        mem_en,
    output logic                        mem_we,
    output logic                        mem_act,
    output logic [ROW_W-1:0]            mem_row,
    output logic [COL_W-1:0]            mem_col,
    output logic [CODE_W-1:0]           mem_wdata,
    input  logic [CODE_W-1:0]           mem_rdata,
    output logic                        rec_valid,
    input  logic                        rec_ready,
    output logic [ROW_W-1:0]            rec_row,
    output logic [COL_W-1:0]            rec_col,
    output logic [CODE_W-1:0]           rec_code,
    output logic [$clog2(CODE_W+1)-1:0] rec_level,
    output logic                        rec_drift,
    output logic                        rec_invalid,
    output logic                        busy,
    output logic                        done
);
    localparam int LVL_W = $clog2(CODE_W + 1);

    tst_state_t state, state_nx;

    logic             go, step, rewind, issue, can_issue;
    logic             col_end, at_last, tmr_expire, tmr_zero;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [LVL_W-1:0] dec_level;
    logic             dec_top, dec_bad;

    assign go        = (state == ST_IDLE) && start;
    assign can_issue = !rec_valid || rec_ready;

    mlc_addr_walk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .row_first (row_first),
        .row_last  (row_last),
        .col_first (col_first),
        .col_last  (col_last),
        .rewind    (rewind),
        .step      (step),
        .row       (cur_row),
        .col       (cur_col),
        .col_end   (col_end),
        .at_last   (at_last)
    );

    mlc_drift_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (drift_cycles),
        .run      (state == ST_WAIT),
        .expire   (tmr_expire),
        .is_zero  (tmr_zero)
    );

    mlc_thermo_decode #(.CODE_W(CODE_W)) u_dec (
        .code   (mem_rdata),
        .level  (dec_level),
        .is_top (dec_top),
        .bad    (dec_bad)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_FILL;
            ST_FILL:  if (at_last) state_nx = tmr_zero ? ST_OPEN : ST_WAIT;
            ST_WAIT:  if (tmr_expire) state_nx = ST_OPEN;
            ST_OPEN:  state_nx = ST_READ;
            ST_READ:  if (can_issue && col_end) state_nx = at_last ? ST_DRAIN : ST_OPEN;
            ST_DRAIN: if (rec_valid && rec_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        mem_en  = 1'b0;
        mem_we  = 1'b0;
        mem_act = 1'b0;
        step    = 1'b0;
        rewind  = 1'b0;
        issue   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FILL: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                step   = !at_last;
                rewind = at_last;
            end
            ST_WAIT: ;
            ST_OPEN: mem_act = 1'b1;
            ST_READ: begin
                issue  = can_issue;
                mem_en = can_issue;
                step   = can_issue;
            end
            ST_DRAIN: ;
            default: ;
        endcase
    end

    assign mem_row   = cur_row;
    assign mem_col   = cur_col;
    assign mem_wdata = '1;
    assign busy      = (state != ST_IDLE);

    // Result record and end pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid   <= 1'b0;
            rec_row     <= '0;
            rec_col     <= '0;
            rec_code    <= '0;
            rec_level   <= '0;
            rec_drift   <= 1'b0;
            rec_invalid <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= (state == ST_DRAIN) && rec_valid && rec_ready;
            if (issue) begin
                rec_valid   <= 1'b1;
                rec_row     <= cur_row;
                rec_col     <= cur_col;
                rec_code    <= mem_rdata;
                rec_level   <= dec_level;
                rec_drift   <= !dec_top;
                rec_invalid <= dec_bad;
            end else if (rec_ready) begin
                rec_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mlc_drift_tester_chk.sv
module mlc_drift_tester_chk #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int CODE_W = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        mem_en,
    input logic                        mem_we,
    input logic                        mem_act,
    input logic [ROW_W-1:0]            mem_row,
    input logic [CODE_W-1:0]           mem_wdata,
    input logic                        rec_valid,
    input logic                        rec_ready,
    input logic [ROW_W-1:0]            rec_row,
    input logic [COL_W-1:0]            rec_col,
    input logic [CODE_W-1:0]           rec_code,
    input logic [$clog2(CODE_W+1)-1:0] rec_level,
    input logic                        rec_drift,
    input logic                        rec_invalid,
    input logic                        busy,
    input logic                        done
);
    AST_WRITE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (&mem_wdata)); // R1

    AST_ACT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act |-> !mem_en); // R3

    AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && $past(mem_en && !mem_we)) |-> $stable(mem_row) || $past(mem_act)); // R3

    AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_drift) |-> (rec_level == ($clog2(CODE_W+1))'(CODE_W) && !rec_invalid)); // R6

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_level <= ($clog2(CODE_W+1))'(CODE_W))); // R5

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_code) && $stable(rec_row) && $stable(rec_col))); // R8

    AST_NO_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |-> !(mem_en && !mem_we)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9
endmodule

bind mlc_drift_tester mlc_drift_tester_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_act     (mem_act),
    .mem_row     (mem_row),
    .mem_wdata   (mem_wdata),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_row     (rec_row),
    .rec_col     (rec_col),
    .rec_code    (rec_code),
    .rec_level   (rec_level),
    .rec_drift   (rec_drift),
    .rec_invalid (rec_invalid),
    .busy        (busy),
    .done        (done)
);

// File: tb/mlc_drift_tester_test.sv
module mlc_drift_tester_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 2;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] row_first = '0, row_last = '0;
    logic [CW-1:0] col_first = '0, col_last = '0;
    logic [31:0]   drift_cycles = '0;
    logic          mem_en, mem_we, mem_act;
    logic [RW-1:0] mem_row;
    logic [CW-1:0] mem_col;
    logic [4:0]    mem_wdata, mem_rdata;
    logic          rec_valid;
    logic          rec_ready = 1'b1;
    logic [RW-1:0] rec_row;
    logic [CW-1:0] rec_col;
    logic [4:0]    rec_code;
    logic [2:0]    rec_level;
    logic          rec_drift, rec_invalid, busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlc_drift_tester #(.ROW_W(RW), .COL_W(CW), .CODE_W(5), .CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .row_first(row_first), .row_last(row_last),
        .col_first(col_first), .col_last(col_last),
        .drift_cycles(drift_cycles),
        .mem_en(mem_en), .mem_we(mem_we), .mem_act(mem_act),
        .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_row(rec_row), .rec_col(rec_col), .rec_code(rec_code),
        .rec_level(rec_level), .rec_drift(rec_drift), .rec_invalid(rec_invalid),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model and run configuration
    logic [4:0] mem [0:3][0:3];
    assign mem_rdata = mem[mem_row][mem_col];

    int t_rf, t_rl, t_cf, t_cl, t_d, t_seed, t_mode;
    int wr_cnt, rd_cnt, act_cnt, rec_cnt, done_cnt, busy_bad;
    int last_wr_cyc, first_act_cyc, last_rd_cyc, last_hs_cyc;
    bit in_run;
    int cyc = 0;
    logic [7:0] lfsr = 8'hA5;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int pat(input int r, input int c);
        return (r * 4 + c + t_seed) % 32;
    endfunction

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 5; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Saved record for the stall check
    bit       hold_prev = 0;
    int       h_row, h_col, h_code;

    always begin
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rec_ready = (t_mode == 0) ? 1'b1 : lfsr[0];
        #1;
        if (rst_n) begin
            int nc, k, er, ec, c;
            nc = t_cl - t_cf + 1;
            if (hold_prev) begin
                chk(rec_valid && rec_row == h_row && rec_col == h_col && rec_code == h_code,
                    "R8 held record", rec_code, h_code);
            end
            hold_prev = rec_valid && !rec_ready;
            h_row = rec_row; h_col = rec_col; h_code = rec_code;
            if (rec_valid && !rec_ready && mem_en && !mem_we)
                chk(0, "R8 read during stall", 1, 0);
            if (mem_en && mem_we) begin
                k = wr_cnt;
                er = t_rf + k / nc; ec = t_cf + k % nc;
                if (mem_row != er || mem_col != ec || mem_wdata != 5'b11111 || act_cnt != 0)
                    chk(0, "R1 fill write", {mem_row, mem_col, mem_wdata}, (er * 4 + ec) * 32 + 31);
                mem[mem_row][mem_col] = mem_wdata;
                wr_cnt++;
                last_wr_cyc = cyc;
            end
            if (mem_act) begin
                if (act_cnt == 0) begin
                    chk(cyc - last_wr_cyc - 1 == t_d, "R2 drift gap", cyc - last_wr_cyc - 1, t_d);
                    first_act_cyc = cyc;
                    for (int r = t_rf; r <= t_rl; r++)
                        for (int cc = t_cf; cc <= t_cl; cc++)
                            mem[r][cc] = 5'(pat(r, cc));
                end
                if (mem_row != t_rf + act_cnt || rd_cnt != act_cnt * nc || mem_en)
                    chk(0, "R3 row open", mem_row, t_rf + act_cnt);
                act_cnt++;
            end
            if (mem_en && !mem_we) begin
                k = rd_cnt;
                er = t_rf + k / nc; ec = t_cf + k % nc;
                if (mem_row != er || mem_col != ec || act_cnt != k / nc + 1)
                    chk(0, "R3 page read", mem_row * 4 + mem_col, er * 4 + ec);
                rd_cnt++;
                last_rd_cyc = cyc;
            end
            if (rec_valid && rec_ready) begin
                k = rec_cnt;
                er = t_rf + k / nc; ec = t_cf + k % nc;
                c = pat(er, ec);
                chk(rec_row == er && rec_col == ec, "R4 record address", rec_row * 4 + rec_col, er * 4 + ec);
                chk(rec_code == c && rec_level == ones(c), "R5 code and level",
                    rec_code * 8 + rec_level, c * 8 + ones(c));
                chk(rec_drift == (c != 31), "R6 drift flag", rec_drift, c != 31);
                chk(rec_invalid == (c != (1 << ones(c)) - 1), "R7 invalid flag",
                    rec_invalid, c != (1 << ones(c)) - 1);
                rec_cnt++;
                last_hs_cyc = cyc;
            end
            if (done) begin
                chk(!busy && cyc == last_hs_cyc + 1, "R9 done timing", cyc, last_hs_cyc + 1);
                done_cnt++;
                in_run = 0;
            end else if (in_run && !busy) begin
                busy_bad++;
            end
        end
    end

    task automatic run_test(input int rf, input int rl, input int cf, input int cl,
                            input int d, input int seed, input int mode, input bit stray);
        int n, nr, nc, guard;
        @(negedge clk);
        t_rf = rf; t_rl = rl; t_cf = cf; t_cl = cl; t_d = d; t_seed = seed; t_mode = mode;
        wr_cnt = 0; rd_cnt = 0; act_cnt = 0; rec_cnt = 0; done_cnt = 0; busy_bad = 0;
        nr = rl - rf + 1; nc = cl - cf + 1; n = nr * nc;
        row_first = RW'(rf); row_last = RW'(rl);
        col_first = CW'(cf); col_last = CW'(cl);
        drift_cycles = 32'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        row_first = '0; row_last = '1; col_first = '0; col_last = '1; drift_cycles = 32'd3;
        #2;
        in_run = 1;
        chk(busy, "R9 busy after start", busy, 1);
        guard = 0;
        if (stray) begin
            while (act_cnt < 1 && guard < 3000) begin @(negedge clk); guard++; end
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
        if (done_cnt == 0) chk(0, "R9 watchdog", guard, 5000);
        repeat (4) @(negedge clk);
        #2;
        chk(wr_cnt == n, "R1 write count", wr_cnt, n);
        chk(rd_cnt == n && act_cnt == nr, "R3 read and open count", rd_cnt * 16 + act_cnt, n * 16 + nr);
        chk(rec_cnt == n, "R4 record count", rec_cnt, n);
        chk(done_cnt == 1 && !busy, "R9 single done", done_cnt, 1);
        chk(busy_bad == 0, "R9 busy held", busy_bad, 0);
        if (mode == 0)
            chk(last_rd_cyc - first_act_cyc + 1 == nr * (nc + 1), "R3 back-to-back reads",
                last_rd_cyc - first_act_cyc + 1, nr * (nc + 1));
        if (stray)
            chk(wr_cnt == n && rec_cnt == n, "R10 stray start ignored", rec_cnt, n);
    endtask

    initial begin
        for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) mem[r][c] = '0;
        t_rf = 0; t_rl = 0; t_cf = 0; t_cl = 0; t_d = 0; t_seed = 0; t_mode = 0;
        in_run = 0;
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !done && !rec_valid && !mem_en && !mem_act, "R11 reset state",
            {busy, done, rec_valid, mem_en, mem_act}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!busy && !rec_valid && !mem_en, "R11 idle after reset", {busy, rec_valid, mem_en}, 0);
        run_test(0, 3, 0, 3, 20, 0, 0, 0);
        run_test(0, 3, 0, 3, 0, 16, 1, 0);
        run_test(1, 2, 1, 3, 5, 7, 1, 1);
        run_test(3, 3, 2, 2, 1, 31, 1, 0);
        run_test(2, 3, 0, 1, 0, 9, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL global watchdog actual %0d expected 0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule